// File: doc/BRIEF.md
# Double-Buffered 10-Bit Pulse-Width Modulator

This block produces one pulse-width modulated output from a 10-bit time base. The upper eight bits of the time base are a period timer. The lower two bits are fine sub-counts, and each sub-count lasts one, four, sixteen or sixty-four clocks, set by a prescale field. Software sets an 8-bit period, an 8-bit duty high byte and a 2-bit duty low field through a small synchronous register port. The block restarts its time base and raises the output whenever the timer passes the period value. It drops the output when the time base reaches the active duty value.

The duty value that software writes is held as a pending value. It is copied into a shadow (slave) copy only at a period boundary, so a duty change never tears the pulse that is running. Software can read the shadow copy but cannot write it. A direction bit decides whether the block drives its pin or leaves it floating. A second input is sampled through a two-stage synchronizer and can be read back.

The register port carries no data stream, so it has no valid/ready handshake and never applies back-pressure. A write is accepted in the cycle that `wr_en` is high, and reads are combinational on `addr`.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, `pwm_drive` and `pwm_out` are 0, and reads of the period (addr 0), duty high (addr 1) and control (addr 2) registers return 0.
- R2: The control register holds mode in [1:0], where 2'b11 means running, prescale select in [3:2], duty low field in [5:4], the float bit in [6] and a spare bit in [7]. Each select code 0, 1, 2 and 3 gives a prescale factor of 1, 4, 16 and 64. While running, one period lasts (period + 1) × 4 × prescale clocks.
- R3: The active duty d = {duty high, duty low}. The output rises at the start of each period and stays high for d × prescale clocks when d < 4 × (period + 1).
- R4: An active duty of 0 keeps the output low for the whole period, with no one-clock pulse.
- R5: An active duty of 4 × (period + 1) or more keeps the output high for the whole period.
- R6: A duty write in the middle of a period does not change the pulse in progress. The value present at the next period boundary takes effect in the following period.
- R7: Reading address 3 returns bits [9:2] of the shadow duty. Writes to address 3 are ignored.
- R8: When the mode changes to running, the time base starts at zero and the output stays low for one full period before the first rising edge.
- R9: `pwm_drive` is 1 only while running with the float bit at 0. While `pwm_drive` is 0, `pwm_out` is 0.
- R10: Writing a mode other than 2'b11 (for example, a control value of 0) stops the block. On the next clock `pwm_drive` and `pwm_out` are 0. The period and duty registers keep their values.
- R11: `pin_in` passes through two flip-flops, and its value is read at bit 0 of address 4. A change appears two clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_in | input | 1 | Asynchronous pin level to be sampled |
| pwm_out | output | 1 | Modulated output level |
| pwm_drive | output | 1 | High when the pin is driven, low for high impedance |

## Verification
The hardest case to reach is a duty write that lands inside a running high phase. It must land after the shadow copy is loaded and before the duty match. The bench counts clocks from the rising edge of the output and issues the write on the fourth high clock of a pulse whose duty is eight ticks. It then measures that pulse and the next one. Prescale corners come from re-arming the block from the stopped state with each select code. The first-period low time is measured from the enabling write, so every measurement starts from a known phase.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int TMR_W  = 8;
  localparam int FINE_W = 2;
  localparam int DIV_W  = 6;

  localparam logic [1:0] MODE_RUN = 2'b11;

  localparam logic [2:0] A_PERIOD = 3'd0;
  localparam logic [2:0] A_DUTYHI = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_SHADOW = 3'd3;
  localparam logic [2:0] A_PIN    = 3'd4;

  typedef struct packed {
    logic       spare;
    logic       float_pin;
    logic [1:0] duty_lo;
    logic [1:0] psel;
    logic [1:0] mode;
  } ctrl_t;

  // terminal count of the clock divider for a prescale select code
  function automatic logic [DIV_W-1:0] pre_limit(input logic [1:0] sel);
    logic [DIV_W-1:0] v;
    case (sel)
      2'd0:    v = DIV_W'(0);
      2'd1:    v = DIV_W'(3);
      2'd2:    v = DIV_W'(15);
      default: v = DIV_W'(63);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int PW = TMR_W,
  parameter int FW = FINE_W,
  localparam int TBW = PW + FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [PW-1:0]  shadow_hi,
  input  logic           pin_in,
  output logic [PW-1:0]  period,
  output logic [TBW-1:0] duty_pend,
  output logic           run,
  output logic [1:0]     psel,
  output logic           float_pin
);
  logic [PW-1:0] period_q;
  logic [PW-1:0] dutyhi_q;
  ctrl_t         ctrl_q;
  logic [1:0]    pin_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      dutyhi_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PERIOD: period_q <= wdata[PW-1:0];
        A_DUTYHI: dutyhi_q <= wdata[PW-1:0];
        A_CTRL:   ctrl_q   <= ctrl_t'(wdata);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sync_q <= '0;
    else        pin_sync_q <= {pin_sync_q[0], pin_in};
  end

  always_comb begin
    case (addr)
      A_PERIOD: rdata = 8'(period_q);
      A_DUTYHI: rdata = 8'(dutyhi_q);
      A_CTRL:   rdata = ctrl_q;
      A_SHADOW: rdata = 8'(shadow_hi);
      A_PIN:    rdata = {7'd0, pin_sync_q[1]};
      default:  rdata = '0;
    endcase
  end

  assign period    = period_q;
  assign duty_pend = {dutyhi_q, ctrl_q.duty_lo[FW-1:0]};
  assign run       = (ctrl_q.mode == MODE_RUN);
  assign psel      = ctrl_q.psel;
  assign float_pin = ctrl_q.float_pin;
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int PW = TMR_W,
  parameter int FW = FINE_W,
  localparam int TBW = PW + FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PW-1:0]  period,
  input  logic [1:0]     psel,
  output logic           step,
  output logic           restart,
  output logic [TBW-1:0] tb_nxt
);
  logic [DIV_W-1:0] div_q;
  logic [TBW-1:0]   tb_q;
  logic [TBW-1:0]   tb_top;

  assign tb_top  = {period, {FW{1'b1}}};
  assign step    = run && (div_q >= pre_limit(psel));
  // a period shortened below the running timer ends at the natural wrap
  assign restart = step && ((tb_q == tb_top) || (&tb_q));
  assign tb_nxt  = restart ? '0 : tb_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tb_q  <= '0;
    end else if (!run) begin
      div_q <= '0;
      tb_q  <= '0;
    end else if (step) begin
      div_q <= '0;
      tb_q  <= tb_nxt;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm10_out.sv
module pwm10_out #(
  parameter int TBW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           step,
  input  logic           restart,
  input  logic [TBW-1:0] tb_nxt,
  input  logic [TBW-1:0] duty_pend,
  output logic [TBW-1:0] shadow,
  output logic           level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      level  <= 1'b0;
    end else if (!run) begin
      level  <= 1'b0;
    end else if (restart) begin
      shadow <= duty_pend;
      level  <= (duty_pend != '0);
    end else if (step && (tb_nxt == shadow)) begin
      level  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int PW = TMR_W,
  parameter int FW = FINE_W,
  localparam int TBW = PW + FW
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       pin_in,
  output logic       pwm_out,
  output logic       pwm_drive
);
  logic [PW-1:0]  period;
  logic [TBW-1:0] duty_pend;
  logic [TBW-1:0] shadow_q;
  logic [TBW-1:0] tb_nxt;
  logic [1:0]     psel;
  logic           run, float_pin, step, restart, out_q;

  pwm10_regs #(.PW(PW), .FW(FW)) u_regs (
    .clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
    .shadow_hi(shadow_q[TBW-1:FW]), .pin_in,
    .period, .duty_pend, .run, .psel, .float_pin
  );

  pwm10_timebase #(.PW(PW), .FW(FW)) u_tb (
    .clk, .rst_n, .run, .period, .psel, .step, .restart, .tb_nxt
  );

  pwm10_out #(.TBW(TBW)) u_out (
    .clk, .rst_n, .run, .step, .restart, .tb_nxt, .duty_pend,
    .shadow(shadow_q), .level(out_q)
  );

  assign pwm_drive = run && !float_pin;
  assign pwm_out   = out_q && pwm_drive;
endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
  parameter int TBW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [2:0]     addr,
  input logic [7:0]     wdata,
  input logic           run,
  input logic           restart,
  input logic [TBW-1:0] shadow,
  input logic           out_q,
  input logic           pwm_out,
  input logic           pwm_drive
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (!run)    seen_q <= 1'b0;
    else if (restart) seen_q <= 1'b1;
  end

  // R3
  rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(restart));
  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow == '0) |-> !out_q);
  // R6
  shadow_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shadow) |-> $past(restart));
  // R7
  shadow_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !restart) |=> $stable(shadow));
  // R8
  first_period_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !seen_q) |-> !out_q);
  // R9
  float_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[6]) |=> !pwm_drive);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[1:0] != 2'b11) |=> (!pwm_drive && !pwm_out));
endmodule

bind pwm10_gen pwm10_gen_chk #(.TBW(TBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run(run), .restart(restart), .shadow(shadow_q), .out_q(out_q),
  .pwm_out(pwm_out), .pwm_drive(pwm_drive)
);

// File: tb/pwm10_gen_tb.sv
`timescale 1ns/1ps
module pwm10_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       pin_in = 1'b0;
  logic [7:0] rdata;
  logic       pwm_out, pwm_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm10_gen u_dut (
    .clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .pin_in, .pwm_out, .pwm_drive
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic count_while(input logic val, input int limit, output int n);
    n = 0;
    while (n < limit && pwm_out === val) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic arm(input int per, input int dhi, input int ctrl);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'(per));
    wr(3'd1, 8'(dhi));
    wr(3'd2, 8'(ctrl));
  endtask

  task automatic t_reset();
    int v;
    check("R1 drive", pwm_drive, 0);
    check("R1 out", pwm_out, 0);
    rd(3'd0, v); check("R1 period", v, 0);
    rd(3'd1, v); check("R1 dutyhi", v, 0);
    rd(3'd2, v); check("R1 ctrl", v, 0);
  endtask

  // R2 R3 R8: first low period, then one high and one low phase
  task automatic t_wave(input int per, input int dhi, input int ctrl);
    int lo0, hi, lo, pre, p, d;
    pre = 1 << (2 * ((ctrl >> 2) & 3));
    p = (per + 1) * 4 * pre;
    d = dhi * 4 + ((ctrl >> 4) & 3);
    arm(per, dhi, ctrl);
    count_while(1'b0, 2000, lo0);
    check("R8 first period low", lo0, p);
    count_while(1'b1, 2000, hi);
    check("R3 high time", hi, d * pre);
    count_while(1'b0, 2000, lo);
    check("R2 period", hi + lo, p);
  endtask

  task automatic t_zero();
    int n;
    arm(3, 0, 8'h03);
    count_while(1'b0, 200, n);
    check("R4 zero duty stays low", n, 200);
  endtask

  task automatic t_full(input int dhi, input int ctrl);
    int lo0, n;
    arm(3, dhi, ctrl);
    count_while(1'b0, 200, lo0);
    check("R5 first low", lo0, 16);
    count_while(1'b1, 100, n);
    check("R5 stays high", n, 100);
  endtask

  // R6 then R7
  task automatic t_midwrite();
    int lo0, hi, lo, hi2, v;
    arm(9, 2, 8'h03);
    count_while(1'b0, 500, lo0);
    hi = 0;
    while (pwm_out === 1'b1 && hi < 500) begin
      if (hi == 3) begin wr_en = 1'b1; addr = 3'd1; wdata = 8'd5; end
      else wr_en = 1'b0;
      hi++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R6 current pulse kept", hi, 8);
    count_while(1'b0, 500, lo);
    check("R6 period intact", hi + lo, 40);
    count_while(1'b1, 500, hi2);
    check("R6 new duty next period", hi2, 20);
    rd(3'd3, v);
    check("R7 shadow read", v, 5);
    wr(3'd3, 8'hAA);
    rd(3'd3, v);
    check("R7 shadow write ignored", v, 5);
    count_while(1'b0, 500, lo);
    count_while(1'b1, 500, hi2);
    check("R7 pulse after shadow write", hi2, 20);
  endtask

  task automatic t_float();
    int hs;
    arm(3, 2, 8'h03);
    wr(3'd2, 8'h43);
    check("R9 float drive", pwm_drive, 0);
    hs = 0;
    for (int i = 0; i < 60; i++) begin
      if (pwm_out) hs++;
      @(negedge clk);
    end
    check("R9 out low while floating", hs, 0);
    wr(3'd2, 8'h03);
    check("R9 drive back", pwm_drive, 1);
  endtask

  task automatic t_stop();
    int v, hs;
    arm(3, 3, 8'h03);
    count_while(1'b0, 100, v);
    wr(3'd2, 8'h00);
    check("R10 drive off", pwm_drive, 0);
    hs = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out) hs++;
      @(negedge clk);
    end
    check("R10 out stays low", hs, 0);
    rd(3'd2, v); check("R10 ctrl cleared", v, 0);
    rd(3'd0, v); check("R10 period kept", v, 3);
    rd(3'd1, v); check("R10 dutyhi kept", v, 3);
  endtask

  task automatic t_pin();
    int v;
    pin_in = 1'b1;
    @(negedge clk);
    rd(3'd4, v); check("R11 one edge not yet", v, 0);
    @(negedge clk);
    rd(3'd4, v); check("R11 two edges", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_wave(4, 3, 8'h23);
    t_wave(2, 1, 8'h17);
    t_wave(1, 1, 8'h3B);
    t_wave(0, 0, 8'h1F);
    t_wave(3, 3, 8'h33);
    t_zero();
    t_full(4, 8'h03);
    t_full(8'hFF, 8'h33);
    t_midwrite();
    t_float();
    t_stop();
    t_pin();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule